// File: doc/BRIEF.md
# Per-Channel Read/Write Bus Turnaround Controller

This block decides, for every pseudo channel of a memory controller, whether the next burst slots on that channel carry reads or writes. Each channel holds its own present direction, a pending next direction and a count of bursts issued in the ongoing run. The channel compares its own read-queue and write-queue occupancy against a high and a low write watermark and against minimum run lengths. A change of direction follows hysteresis: writes are allowed to build up before the bus turns toward them, and a write run stops only when writes have drained or reads have waited long enough.

A turnaround takes two steps. First the decision is latched as the pending direction. Then, one cycle later, the present direction takes that value. At that point the channel pulses a turnaround flag and reports the length of the run that just ended, so that statistics can be collected. A shared drain request makes a read-idle channel flush any queued writes and holds a write run open.

The block also holds one candidate picker per channel. Each picker scans a shared list of queue entries and chooses the lowest-index entry that belongs to its own channel, is ready, and matches that channel's present direction. Entries tagged for the other channel are passed over.

Top module: `bus_turn_ctrl`

## Requirements
- R1: After reset every channel is in the read direction (`dir_wr_o` bit 0), with `turn_o` low and `run_len_o` zero.
- R2: A channel in read direction with no reads queued turns to writes when its write occupancy is non-zero and either `drain_i` is high or occupancy is greater than the low watermark LOW_WM = WR_BUF*LOW_PCT/100. Occupancy equal to LOW_WM does not turn it.
- R3: A channel in read direction turns to writes when its write occupancy is greater than HIGH_WM = WR_BUF*HIGH_PCT/100 and at least MIN_RD reads have been issued in the run, or its read queue is empty.
- R4: A channel in write direction turns back to reads when its write occupancy is zero.
- R5: A channel in write direction turns back to reads when write occupancy plus MIN_WR is below LOW_WM and `drain_i` is low. While `drain_i` is high, this rule does not apply.
- R6: A channel in write direction turns back to reads when reads are queued and at least MIN_WR writes have been issued in the run.
- R7: A condition first present in cycle t sets the pending direction at edge t+1. `dir_wr_o` flips at edge t+2, together with a one-cycle `turn_o` pulse. At that same edge `run_len_o` takes the number of bursts issued in the ended run, saturated at 2^RUN_W-1, and the run count restarts from zero.
- R8: A burst strobe whose kind (`burst_wr_i`, 1 = write) differs from the channel's present direction is not counted in the run.
- R9: Each channel's direction, pulse and run length depend only on that channel's own inputs and the shared drain request.
- R10: A channel's picker reports the lowest-index entry that is valid and ready, whose tag (field c of `ent_ch_i`, CH_W bits) equals the channel number, and whose kind bit in `ent_wr_i` equals that channel's `dir_wr_o`. If no entry qualifies, `pick_vld_o` is low and the index is zero.
- R11: A configuration whose low watermark exceeds its high watermark is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| drain_i | input | 1 | Shared request to flush queued writes |
| rd_occ_i | input | NUM_CH*OCC_W | Read-queue occupancy per channel, channel c at bits [c*OCC_W +: OCC_W] |
| wr_occ_i | input | NUM_CH*OCC_W | Write-queue occupancy per channel |
| burst_vld_i | input | NUM_CH | Burst issued on channel c this cycle |
| burst_wr_i | input | NUM_CH | Kind of that burst, 1 = write |
| ent_vld_i | input | ENTRIES | Queue entry holds a packet |
| ent_rdy_i | input | ENTRIES | Entry can issue now |
| ent_wr_i | input | ENTRIES | Entry kind, 1 = write |
| ent_ch_i | input | ENTRIES*CH_W | Channel tag of each entry |
| dir_wr_o | output | NUM_CH | Present direction per channel, 1 = write |
| turn_o | output | NUM_CH | One-cycle turnaround pulse per channel |
| run_len_o | output | NUM_CH*RUN_W | Length of the most recently ended run per channel |
| pick_vld_o | output | NUM_CH | Picker found a candidate |
| pick_idx_o | output | NUM_CH*IDX_W | Index of the chosen entry per channel |

## Verification
Direction decisions are due two clock edges after the occupancy or drain condition appears. For a condition produced by a burst strobe, the count includes the strobe at the edge that samples it, so the two edges are counted from the cycle after it. The bench drives every input at a falling edge. It samples one falling edge later, to confirm the old direction still holds, then one more, to see the flipped direction with `turn_o` and `run_len_o`, then a third, to confirm the pulse has ended. Negative cases hold the stimulus for several cycles and check that no flip occurs. The pickers are combinational and are checked at the falling edge after their inputs change.

// File: rtl/bus_turn_pkg.sv
package bus_turn_pkg;

  // Read-direction exit rule: idle reads with writes worth serving, or
  // writes piling past the high mark after a long enough read run.
  function automatic logic bt_leave_read(input int unsigned rd, input int unsigned wr,
                                         input int unsigned run, input int unsigned lo,
                                         input int unsigned hi, input int unsigned min_rd,
                                         input logic drain);
    logic rd_idle;
    rd_idle = (rd == 0);
    return (rd_idle && (wr != 0) && (drain || (wr > lo))) ||
           ((wr > hi) && ((run >= min_rd) || rd_idle));
  endfunction

  // Write-direction exit rule: empty, well under the low mark, or reads
  // starved after a long enough write run.
  function automatic logic bt_leave_write(input int unsigned rd, input int unsigned wr,
                                          input int unsigned run, input int unsigned lo,
                                          input int unsigned min_wr, input logic drain);
    return (wr == 0) ||
           (((wr + min_wr) < lo) && !drain) ||
           ((rd != 0) && (run >= min_wr));
  endfunction

endpackage

// File: rtl/bus_turn_chan.sv
module bus_turn_chan
  import bus_turn_pkg::*;
#(
  parameter int OCC_W   = 7,
  parameter int RUN_W   = 8,
  parameter int HIGH_WM = 54,
  parameter int LOW_WM  = 32,
  parameter int MIN_RD  = 64,
  parameter int MIN_WR  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drain_i,
  input  logic [OCC_W-1:0] rd_occ_i,
  input  logic [OCC_W-1:0] wr_occ_i,
  input  logic             burst_vld_i,
  input  logic             burst_wr_i,
  output logic             dir_wr_o,
  output logic             turn_o,
  output logic [RUN_W-1:0] run_len_o
);

  logic             cur_wr;
  logic             nxt_wr;
  logic [RUN_W-1:0] run_cnt;
  logic [RUN_W-1:0] run_inc;
  logic             turn_due;
  logic             burst_hit;
  logic             flip_req;

  assign turn_due  = (cur_wr != nxt_wr);
  assign burst_hit = burst_vld_i && (burst_wr_i == cur_wr);
  assign run_inc   = (burst_hit && (run_cnt != {RUN_W{1'b1}})) ? run_cnt + 1'b1 : run_cnt;

  always_comb begin
    if (cur_wr)
      flip_req = bt_leave_write(int'(rd_occ_i), int'(wr_occ_i), int'(run_cnt),
                                LOW_WM, MIN_WR, drain_i);
    else
      flip_req = bt_leave_read(int'(rd_occ_i), int'(wr_occ_i), int'(run_cnt),
                               LOW_WM, HIGH_WM, MIN_RD, drain_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cur_wr    <= 1'b0;
      nxt_wr    <= 1'b0;
      run_cnt   <= '0;
      turn_o    <= 1'b0;
      run_len_o <= '0;
    end else begin
      turn_o <= turn_due;
      if (turn_due) begin
        cur_wr    <= nxt_wr;
        run_len_o <= run_inc;
        run_cnt   <= '0;
      end else begin
        run_cnt <= run_inc;
        if (flip_req) nxt_wr <= ~cur_wr;
      end
    end
  end

  assign dir_wr_o = cur_wr;

  AST_TURN_FLIPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_o |-> (dir_wr_o != $past(dir_wr_o))); // R7

  AST_DIR_HOLDS_OFF_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !turn_o |-> $stable(dir_wr_o)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_o |=> !turn_o); // R7

  AST_EMPTY_WQ_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_wr && !turn_due && (wr_occ_i == '0)) |=> !nxt_wr); // R4

  AST_RUN_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_o |-> (run_cnt == '0)); // R7

endmodule

// File: rtl/bus_turn_pick.sv
module bus_turn_pick #(
  parameter int ENTRIES = 8,
  parameter int CH_W    = 1,
  parameter int CH_ID   = 0,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dir_wr_i,
  input  logic [ENTRIES-1:0]      ent_vld_i,
  input  logic [ENTRIES-1:0]      ent_rdy_i,
  input  logic [ENTRIES-1:0]      ent_wr_i,
  input  logic [ENTRIES*CH_W-1:0] ent_ch_i,
  output logic                    pick_vld_o,
  output logic [IDX_W-1:0]        pick_idx_o
);

  logic [ENTRIES-1:0] elig;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_elig
    assign elig[e] = ent_vld_i[e] && ent_rdy_i[e] && (ent_wr_i[e] == dir_wr_i) &&
                     (ent_ch_i[e*CH_W +: CH_W] == CH_W'(CH_ID));
  end

  // Scan from the top so that the lowest eligible index is written last.
  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = IDX_W'(i);
      end
    end
  end

  AST_PICK_OWN_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld_o |-> (ent_ch_i[pick_idx_o*CH_W +: CH_W] == CH_W'(CH_ID))); // R10

  AST_PICK_KIND_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_vld_o |-> (ent_vld_i[pick_idx_o] && ent_rdy_i[pick_idx_o] &&
                    (ent_wr_i[pick_idx_o] == dir_wr_i))); // R10

  AST_NO_PICK_ZERO_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pick_vld_o |-> (pick_idx_o == '0)); // R10

endmodule

// File: rtl/bus_turn_ctrl.sv
module bus_turn_ctrl #(
  parameter int NUM_CH   = 2,
  parameter int OCC_W    = 7,
  parameter int RUN_W    = 8,
  parameter int WR_BUF   = 64,
  parameter int HIGH_PCT = 85,
  parameter int LOW_PCT  = 50,
  parameter int MIN_RD   = 64,
  parameter int MIN_WR   = 64,
  parameter int ENTRIES  = 8,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      drain_i,
  input  logic [NUM_CH*OCC_W-1:0]   rd_occ_i,
  input  logic [NUM_CH*OCC_W-1:0]   wr_occ_i,
  input  logic [NUM_CH-1:0]         burst_vld_i,
  input  logic [NUM_CH-1:0]         burst_wr_i,
  input  logic [ENTRIES-1:0]        ent_vld_i,
  input  logic [ENTRIES-1:0]        ent_rdy_i,
  input  logic [ENTRIES-1:0]        ent_wr_i,
  input  logic [ENTRIES*CH_W-1:0]   ent_ch_i,
  output logic [NUM_CH-1:0]         dir_wr_o,
  output logic [NUM_CH-1:0]         turn_o,
  output logic [NUM_CH*RUN_W-1:0]   run_len_o,
  output logic [NUM_CH-1:0]         pick_vld_o,
  output logic [NUM_CH*IDX_W-1:0]   pick_idx_o
);

  localparam int HIGH_WM = (WR_BUF * HIGH_PCT) / 100;
  localparam int LOW_WM  = (WR_BUF * LOW_PCT) / 100;

  // R11: watermark ordering is a configuration rule
  if (LOW_WM > HIGH_WM) begin : g_bad_wm
    $error("bus_turn_ctrl: low write watermark above high watermark");
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bus_turn_chan #(
      .OCC_W  (OCC_W),
      .RUN_W  (RUN_W),
      .HIGH_WM(HIGH_WM),
      .LOW_WM (LOW_WM),
      .MIN_RD (MIN_RD),
      .MIN_WR (MIN_WR)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .drain_i    (drain_i),
      .rd_occ_i   (rd_occ_i[c*OCC_W +: OCC_W]),
      .wr_occ_i   (wr_occ_i[c*OCC_W +: OCC_W]),
      .burst_vld_i(burst_vld_i[c]),
      .burst_wr_i (burst_wr_i[c]),
      .dir_wr_o   (dir_wr_o[c]),
      .turn_o     (turn_o[c]),
      .run_len_o  (run_len_o[c*RUN_W +: RUN_W])
    );

    bus_turn_pick #(
      .ENTRIES(ENTRIES),
      .CH_W   (CH_W),
      .CH_ID  (c)
    ) u_pick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dir_wr_i  (dir_wr_o[c]),
      .ent_vld_i (ent_vld_i),
      .ent_rdy_i (ent_rdy_i),
      .ent_wr_i  (ent_wr_i),
      .ent_ch_i  (ent_ch_i),
      .pick_vld_o(pick_vld_o[c]),
      .pick_idx_o(pick_idx_o[c*IDX_W +: IDX_W])
    );
  end

endmodule

// File: tb/bus_turn_ctrl_bench.sv
module bus_turn_ctrl_bench;

  localparam int NCH = 2;
  localparam int OW  = 7;
  localparam int RW  = 8;
  localparam int BUF = 32;
  localparam int HP  = 75;
  localparam int LP  = 50;
  localparam int MR  = 4;
  localparam int MW  = 4;
  localparam int NE  = 8;
  localparam int IW  = 3;
  // Watermarks restated from R2/R3: BUF*pct/100
  localparam int HI_T = BUF * HP / 100;  // 24
  localparam int LO_T = BUF * LP / 100;  // 16
  localparam int SAT  = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drain = 1'b0;
  logic [OW-1:0] rd_q [NCH];
  logic [OW-1:0] wr_q [NCH];
  logic [NCH-1:0] bvld = '0;
  logic [NCH-1:0] bwr = '0;
  logic [NE-1:0] e_vld = '0, e_rdy = '0, e_wr = '0, e_ch = '0;
  logic [NCH-1:0] dir_wr, turn, pvld;
  logic [NCH*RW-1:0] rlen;
  logic [NCH*IW-1:0] pidx;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  bus_turn_ctrl #(
    .NUM_CH(NCH), .OCC_W(OW), .RUN_W(RW), .WR_BUF(BUF), .HIGH_PCT(HP),
    .LOW_PCT(LP), .MIN_RD(MR), .MIN_WR(MW), .ENTRIES(NE)
  ) u_bus_turn_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .drain_i(drain),
    .rd_occ_i({rd_q[1], rd_q[0]}), .wr_occ_i({wr_q[1], wr_q[0]}),
    .burst_vld_i(bvld), .burst_wr_i(bwr),
    .ent_vld_i(e_vld), .ent_rdy_i(e_rdy), .ent_wr_i(e_wr), .ent_ch_i(e_ch),
    .dir_wr_o(dir_wr), .turn_o(turn), .run_len_o(rlen),
    .pick_vld_o(pvld), .pick_idx_o(pidx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; drain = 1'b0; bvld = '0; bwr = '0;
    rd_q[0] = 3; wr_q[0] = 0; rd_q[1] = 3; wr_q[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic burst(input int ch, input bit w, input int n);
    for (int i = 0; i < n; i++) begin
      bvld[ch] = 1'b1; bwr[ch] = w;
      @(negedge clk);
    end
    bvld[ch] = 1'b0; bwr[ch] = 1'b0;
  endtask

  // Direction must stay put and no pulse for n cycles.
  task automatic stay(input int ch, input bit w, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dir_wr[ch] == w && !turn[ch], {tag, " hold"}, int'(dir_wr[ch]), int'(w));
    end
  endtask

  // Stimulus present now: pending at edge 1, flip and pulse at edge 2.
  task automatic expect_turn(input int ch, input bit w, input int len, input string tag);
    int oc;
    oc = 1 - ch;
    @(negedge clk);
    chk(dir_wr[ch] == !w && !turn[ch], {tag, " not yet"}, int'(dir_wr[ch]), int'(!w));
    @(negedge clk);
    chk(dir_wr[ch] == w, {tag, " dir"}, int'(dir_wr[ch]), int'(w));
    chk(turn[ch] == 1'b1, {tag, " pulse"}, int'(turn[ch]), 1);
    chk(int'(rlen[ch*RW +: RW]) == len, {tag, " run_len"}, int'(rlen[ch*RW +: RW]), len);
    chk(turn[oc] == 1'b0 && dir_wr[oc] == 1'b0, "R9 other channel quiet",
        int'(dir_wr[oc]), 0);
    @(negedge clk);
    chk(turn[ch] == 1'b0, {tag, " pulse one cycle"}, int'(turn[ch]), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(dir_wr == '0, "R1 dir after reset", int'(dir_wr), 0);
    chk(turn == '0, "R1 turn after reset", int'(turn), 0);
    chk(rlen == '0, "R1 run_len after reset", int'(rlen), 0);
  endtask

  task automatic t_low_mark();
    do_reset();
    rd_q[0] = 0; wr_q[0] = OW'(LO_T);
    stay(0, 1'b0, 4, "R2 at low mark");
    wr_q[0] = OW'(LO_T + 1);
    expect_turn(0, 1'b1, 0, "R2 above low mark");
  endtask

  task automatic t_drain();
    do_reset();
    rd_q[0] = 0; wr_q[0] = 1; drain = 1'b1;
    expect_turn(0, 1'b1, 0, "R2 drain");
    burst(0, 1'b1, 2);
    burst(0, 1'b0, 1);
    stay(0, 1'b1, 3, "R5 drain holds write");
    drain = 1'b0;
    expect_turn(0, 1'b0, 2, "R5 R8 below low exit");
  endtask

  task automatic t_high_mark();
    do_reset();
    rd_q[0] = 5; wr_q[0] = OW'(HI_T + 1);
    burst(0, 1'b0, MR - 1);
    stay(0, 1'b0, 4, "R3 short read run");
    burst(0, 1'b0, 1);
    expect_turn(0, 1'b1, MR, "R3 high mark");
    burst(0, 1'b1, MW - 1);
    stay(0, 1'b1, 3, "R6 short write run");
    burst(0, 1'b1, 1);
    expect_turn(0, 1'b0, MW, "R6 reads waiting");
  endtask

  task automatic t_empty();
    do_reset();
    rd_q[0] = 0; wr_q[0] = 20;
    expect_turn(0, 1'b1, 0, "R4 enter write");
    rd_q[0] = 3;
    stay(0, 1'b1, 3, "R4 writes remain");
    wr_q[0] = 0;
    expect_turn(0, 1'b0, 0, "R4 empty exit");
  endtask

  task automatic t_sat();
    do_reset();
    rd_q[0] = 5; wr_q[0] = 0;
    burst(0, 1'b0, 300);
    rd_q[0] = 0; wr_q[0] = 1; drain = 1'b1;
    expect_turn(0, 1'b1, SAT, "R7 saturated run");
    drain = 1'b0;
  endtask

  task automatic t_other_chan();
    do_reset();
    rd_q[0] = 3; wr_q[0] = 0;
    rd_q[1] = 0; wr_q[1] = OW'(LO_T + 1);
    expect_turn(1, 1'b1, 0, "R9 channel 1 alone");
    chk(dir_wr[0] == 1'b0, "R9 channel 0 stays read", int'(dir_wr[0]), 0);
  endtask

  task automatic t_pick();
    do_reset();
    // entries 0,1,2,3,5 valid; entry 0 on channel 1; entry 1 write; entry 2 not ready
    e_vld = 8'b0010_1111; e_ch = 8'b0000_0001; e_wr = 8'b0000_0010; e_rdy = 8'b1111_1011;
    @(negedge clk);
    chk(pvld[0] && pidx[2:0] == 3'd3, "R10 ch0 read pick", int'(pidx[2:0]), 3);
    chk(pvld[1] && pidx[5:3] == 3'd0, "R10 ch1 read pick", int'(pidx[5:3]), 0);
    rd_q[0] = 0; wr_q[0] = 20;
    expect_turn(0, 1'b1, 0, "R10 ch0 to write");
    chk(pvld[0] && pidx[2:0] == 3'd1, "R10 ch0 write pick", int'(pidx[2:0]), 1);
    e_vld = '0;
    @(negedge clk);
    chk(!pvld[0] && pidx[2:0] == 3'd0, "R10 ch0 none", int'(pidx[2:0]), 0);
    chk(!pvld[1] && pidx[5:3] == 3'd0, "R10 ch1 none", int'(pidx[5:3]), 0);
  endtask

  initial begin
    rd_q[0] = 0; wr_q[0] = 0; rd_q[1] = 0; wr_q[1] = 0;
    t_reset();
    t_low_mark();
    t_drain();
    t_high_mark();
    t_empty();
    t_sat();
    t_other_chan();
    t_pick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule